// File: doc/BRIEF.md
# Processor Interface Acknowledge and Control Registers

This block is the register front end that one processor uses to talk to its private interrupt state bank. The processor selects a register with a small select code and issues a one-cycle read or write strobe with 64-bit data. Reading the acknowledge register takes the lowest-numbered interrupt whose pending bit is set. The block returns its number and tells the state bank to mark that interrupt active. Writing an interrupt number to the end-of-interrupt register tells the state bank to clear that interrupt's active bit.

Alongside these two, the block holds the configuration the processor sees: an 8-bit priority mask, a 3-bit binary point for each of the two interrupt groups, and one enable bit per group. The group-0 enable gates the fast interrupt line and the group-1 enable gates the normal interrupt line. A read-only control word describes the interface's capabilities. Every result appears one clock after its strobe. An access the block does not support reads as zero and raises an error pulse.

Register select codes: 0 acknowledge (read only), 1 end of interrupt (write only), 2 priority mask, 3 group-0 binary point, 4 group-1 binary point, 5 group-0 enable, 6 group-1 enable, 7 control word. Codes 8 to 15 are not supported.

Top module: `cpuif_ack`

## Requirements
- R1: A read strobe with select 0 while `pend_bits` is nonzero returns, one cycle later, `rd_vld`=1 and `rd_data` equal to the index of the lowest set bit of `pend_bits`. In the same cycle it pulses `act_set` for one cycle with `act_set_id` equal to that index.
- R2: A read strobe with select 0 while `pend_bits` is zero returns `rd_data`=1023 one cycle later and produces no `act_set` pulse.
- R3: A write strobe with select 1 and data below 32 pulses `act_clr` one cycle later with `act_clr_id` equal to the written value, and raises no error.
- R4: A write strobe with select 1 and data of 32 or more produces no `act_clr` pulse and raises `acc_err` for one cycle.
- R5: Select 2 keeps the low 8 bits of a write. A later read returns them, with all higher bits zero.
- R6: Selects 3 and 4 each keep only the low 3 bits of a write and read back those 3 bits. A write to one leaves the other unchanged.
- R7: Selects 5 and 6 each keep bit 0 of a write and read it back in bit 0. The group-0 bit drives `fiq_en` and the group-1 bit drives `irq_en`, and each output changes one cycle after the write.
- R8: Select 7 always reads 0x440: bit 6 set for the priority-mask hint, bits 10:8 equal to 4 for the priority bits, and bits 13:11 equal to 0 for 16-bit interrupt IDs. A write to it is accepted without error and has no effect.
- R9: A read of select 1, a write of select 0, or any access to select 8 to 15 raises `acc_err` for one cycle. A read of this kind returns `rd_vld`=1 with `rd_data`=0. None of them changes any register or issues any active-bit command.
- R10: Read and write strobes in the same cycle raise `acc_err`, return `rd_vld`=1 with `rd_data`=0, and change nothing.
- R11: After reset, every output is 0, and the priority mask, both binary points and both enables read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 4 | Register select code |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_data | input | 64 | Write data |
| pend_bits | input | 32 | Pending bitmap from the state bank |
| rd_data | output | 64 | Read data, valid with rd_vld |
| rd_vld | output | 1 | Read result valid, one cycle after rd_stb |
| act_set | output | 1 | Command: set the active bit of act_set_id |
| act_set_id | output | 5 | Interrupt to mark active |
| act_clr | output | 1 | Command: clear the active bit of act_clr_id |
| act_clr_id | output | 5 | Interrupt to mark inactive |
| fiq_en | output | 1 | Group-0 enable, gates the fast interrupt line |
| irq_en | output | 1 | Group-1 enable, gates the normal interrupt line |
| acc_err | output | 1 | One-cycle pulse on an unsupported access |

## Verification
A fault in the pending scan shows on the very next cycle, as a wrong number on `rd_data` together with a wrong `act_set_id`. The two must always agree, and the selected bit must be the lowest one set. A corrupted configuration register has no visible effect until it is read back or, for the enables, until `fiq_en`/`irq_en` move. For that reason the bench follows each write with a read, and it also reads back after rejected accesses. A bad decode shows one cycle after the strobe, as a stray error pulse or a stray active-bit command.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_ACK   = 4'd0,
    SEL_EOI   = 4'd1,
    SEL_PMASK = 4'd2,
    SEL_BP0   = 4'd3,
    SEL_BP1   = 4'd4,
    SEL_GEN0  = 4'd5,
    SEL_GEN1  = 4'd6,
    SEL_CTRL  = 4'd7
  } sel_e;

  // control word fields
  localparam int CTRL_HINT_BIT = 6;
  localparam int CTRL_PRI_LSB  = 8;
  localparam int CTRL_PRI_VAL  = 4;
  localparam int CTRL_ID_LSB   = 11;
  localparam int CTRL_ID_VAL   = 0;

  typedef struct packed {
    logic ack_rd;
    logic eoi_wr;
    logic pmask_wr;
    logic bp0_wr;
    logic bp1_wr;
    logic gen0_wr;
    logic gen1_wr;
    logic cfg_rd;
    logic bad;
  } dec_t;

  function automatic logic [63:0] ctrl_word();
    logic [63:0] w;
    w = '0;
    w[CTRL_HINT_BIT] = 1'b1;
    w[CTRL_PRI_LSB +: 3] = 3'(CTRL_PRI_VAL);
    w[CTRL_ID_LSB +: 3] = 3'(CTRL_ID_VAL);
    return w;
  endfunction

  // index of lowest set bit, 0 when none
  function automatic int lowest_set(logic [63:0] v);
    int idx;
    idx = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  function automatic logic id_in_range(logic [63:0] v, int n);
    return v < 64'(n);
  endfunction

endpackage

// File: rtl/cpuif_sel_decode.sv
module cpuif_sel_decode
  import cpuif_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             rd_stb,
  input  logic             wr_stb,
  output dec_t             dec
);

  always_comb begin
    dec = '0;
    if (rd_stb && wr_stb) begin
      dec.bad = 1'b1;
    end else if (rd_stb) begin
      case (sel)
        SEL_ACK:                                   dec.ack_rd = 1'b1;
        SEL_PMASK, SEL_BP0, SEL_BP1,
        SEL_GEN0, SEL_GEN1, SEL_CTRL:              dec.cfg_rd = 1'b1;
        default:                                   dec.bad    = 1'b1;
      endcase
    end else if (wr_stb) begin
      case (sel)
        SEL_EOI:   dec.eoi_wr   = 1'b1;
        SEL_PMASK: dec.pmask_wr = 1'b1;
        SEL_BP0:   dec.bp0_wr   = 1'b1;
        SEL_BP1:   dec.bp1_wr   = 1'b1;
        SEL_GEN0:  dec.gen0_wr  = 1'b1;
        SEL_GEN1:  dec.gen1_wr  = 1'b1;
        SEL_CTRL:  ;
        default:   dec.bad      = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/cpuif_pend_pick.sv
module cpuif_pend_pick
  import cpuif_pkg::*;
#(
  parameter int N_INT = 32,
  localparam int IDX_W = $clog2(N_INT)
) (
  input  logic [N_INT-1:0] pend,
  output logic             found,
  output logic [IDX_W-1:0] id
);

  always_comb begin
    found = |pend;
    id    = IDX_W'(lowest_set(64'(pend)));
  end

endmodule

// File: rtl/cpuif_cfg_bank.sv
module cpuif_cfg_bank
  import cpuif_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int BP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dec_t              dec,
  input  logic [PRIO_W-1:0] wdat,
  output logic [PRIO_W-1:0] pmask,
  output logic [BP_W-1:0]   bp0,
  output logic [BP_W-1:0]   bp1,
  output logic              en0,
  output logic              en1
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmask <= '0;
      bp0   <= '0;
      bp1   <= '0;
      en0   <= 1'b0;
      en1   <= 1'b0;
    end else begin
      if (dec.pmask_wr) pmask <= wdat;
      if (dec.bp0_wr)   bp0   <= wdat[BP_W-1:0];
      if (dec.bp1_wr)   bp1   <= wdat[BP_W-1:0];
      if (dec.gen0_wr)  en0   <= wdat[0];
      if (dec.gen1_wr)  en1   <= wdat[0];
    end
  end

endmodule

// File: rtl/cpuif_ack.sv
module cpuif_ack
  import cpuif_pkg::*;
#(
  parameter int N_INT     = 32,
  parameter int DATA_W    = 64,
  parameter int PRIO_W    = 8,
  parameter int BP_W      = 3,
  parameter int NO_INT_ID = 1023,
  localparam int IDX_W    = $clog2(N_INT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_INT-1:0]  pend_bits,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              act_set,
  output logic [IDX_W-1:0]  act_set_id,
  output logic              act_clr,
  output logic [IDX_W-1:0]  act_clr_id,
  output logic              fiq_en,
  output logic              irq_en,
  output logic              acc_err
);

  dec_t              dec;
  logic              pick_found;
  logic [IDX_W-1:0]  pick_id;
  logic [PRIO_W-1:0] pmask;
  logic [BP_W-1:0]   bp0;
  logic [BP_W-1:0]   bp1;
  logic              en0;
  logic              en1;
  logic [DATA_W-1:0] rd_next;

  // named events for the checker
  logic ack_fire;
  logic eoi_fire;
  logic eoi_reject;

  cpuif_sel_decode u_dec (
    .sel    (sel),
    .rd_stb (rd_stb),
    .wr_stb (wr_stb),
    .dec    (dec)
  );

  cpuif_pend_pick #(.N_INT(N_INT)) u_pick (
    .pend  (pend_bits),
    .found (pick_found),
    .id    (pick_id)
  );

  cpuif_cfg_bank #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .dec   (dec),
    .wdat  (wr_data[PRIO_W-1:0]),
    .pmask (pmask),
    .bp0   (bp0),
    .bp1   (bp1),
    .en0   (en0),
    .en1   (en1)
  );

  assign ack_fire   = dec.ack_rd;
  assign eoi_fire   = dec.eoi_wr & id_in_range(64'(wr_data), N_INT);
  assign eoi_reject = dec.eoi_wr & ~id_in_range(64'(wr_data), N_INT);

  always_comb begin
    rd_next = '0;
    if (dec.ack_rd) begin
      rd_next = pick_found ? DATA_W'(pick_id) : DATA_W'(NO_INT_ID);
    end else if (dec.cfg_rd) begin
      case (sel)
        SEL_PMASK: rd_next = DATA_W'(pmask);
        SEL_BP0:   rd_next = DATA_W'(bp0);
        SEL_BP1:   rd_next = DATA_W'(bp1);
        SEL_GEN0:  rd_next = DATA_W'(en0);
        SEL_GEN1:  rd_next = DATA_W'(en1);
        SEL_CTRL:  rd_next = DATA_W'(ctrl_word());
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data    <= '0;
      rd_vld     <= 1'b0;
      act_set    <= 1'b0;
      act_set_id <= '0;
      act_clr    <= 1'b0;
      act_clr_id <= '0;
      acc_err    <= 1'b0;
    end else begin
      rd_vld  <= rd_stb;
      if (rd_stb) rd_data <= rd_next;
      act_set <= ack_fire & pick_found;
      if (ack_fire & pick_found) act_set_id <= pick_id;
      act_clr <= eoi_fire;
      if (eoi_fire) act_clr_id <= wr_data[IDX_W-1:0];
      acc_err <= dec.bad | eoi_reject;
    end
  end

  assign fiq_en = en0;
  assign irq_en = en1;

endmodule

// File: rtl/cpuif_ack_chk.sv
module cpuif_ack_chk
  import cpuif_pkg::*;
#(
  parameter int N_INT  = 32,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(N_INT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  sel,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wr_data,
  input logic [N_INT-1:0]  pend_bits,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_vld,
  input logic              act_set,
  input logic [IDX_W-1:0]  act_set_id,
  input logic              act_clr,
  input logic [IDX_W-1:0]  act_clr_id,
  input logic              fiq_en,
  input logic              irq_en,
  input logic              acc_err,
  input logic              ack_fire,
  input logic              eoi_fire,
  input logic              eoi_reject
);

  a_r1_grant_matches_read: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && (pend_bits != '0) |=> act_set && rd_vld && (rd_data == DATA_W'(act_set_id)));

  a_r1_grant_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
    act_set |-> ((($past(pend_bits) >> act_set_id) & N_INT'(1)) != '0));

  a_r1_grant_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    act_set |-> (($past(pend_bits) << (N_INT - int'(act_set_id))) == '0));

  a_r2_empty_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && (pend_bits == '0) |=> !act_set && (rd_data == DATA_W'(1023)));

  a_r3_eoi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |=> act_clr && (act_clr_id == $past(wr_data[IDX_W-1:0])));

  a_r4_eoi_reject: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_reject |=> acc_err && !act_clr);

  a_r9_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(rd_stb || wr_stb));

  a_r10_one_command: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_set, act_clr}));

  a_r7_fiq_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fiq_en) |-> $past(wr_stb && !rd_stb && sel == SEL_GEN0));

  a_r7_irq_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_en) |-> $past(wr_stb && !rd_stb && sel == SEL_GEN1));

endmodule

bind cpuif_ack cpuif_ack_chk #(.N_INT(N_INT), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/cpuif_ack_tb.sv
module cpuif_ack_tb;
  import cpuif_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sel = '0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [63:0] wr_data = '0;
  logic [31:0] pend_bits = '0;
  logic [63:0] rd_data;
  logic        rd_vld;
  logic        act_set;
  logic [4:0]  act_set_id;
  logic        act_clr;
  logic [4:0]  act_clr_id;
  logic        fiq_en;
  logic        irq_en;
  logic        acc_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cpuif_ack u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .pend_bits(pend_bits), .rd_data(rd_data), .rd_vld(rd_vld),
    .act_set(act_set), .act_set_id(act_set_id), .act_clr(act_clr),
    .act_clr_id(act_clr_id), .fiq_en(fiq_en), .irq_en(irq_en), .acc_err(acc_err)
  );

  typedef struct {
    bit          vld;
    logic [63:0] data;
    bit          set;
    int          sid;
    bit          clr;
    int          cid;
    bit          err;
    string       tag;
  } exp_t;

  exp_t q[$];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t mk(bit vld, logic [63:0] data, bit set, int sid,
                              bit clr, int cid, bit err, string tag);
    exp_t e;
    e.vld = vld; e.data = data; e.set = set; e.sid = sid;
    e.clr = clr; e.cid = cid; e.err = err; e.tag = tag;
    return e;
  endfunction

  // driver: one strobe cycle, expectation queued for the monitor
  task automatic access(bit r, bit w, logic [3:0] s, logic [63:0] d, exp_t e);
    @(negedge clk);
    rd_stb = r; wr_stb = w; sel = s; wr_data = d;
    q.push_back(e);
    @(negedge clk);
    rd_stb = 0; wr_stb = 0;
  endtask

  task automatic rd(logic [3:0] s, logic [63:0] exp, string tag);
    access(1, 0, s, '0, mk(1, exp, 0, 0, 0, 0, 0, tag));
  endtask

  task automatic wr(logic [3:0] s, logic [63:0] d, string tag);
    access(0, 1, s, d, mk(0, '0, 0, 0, 0, 0, 0, tag));
  endtask

  // monitor
  bit mon_was;
  always @(posedge clk) begin
    mon_was = rd_stb | wr_stb;
    #1;
    if (rst_n && !done) begin
      if (mon_was && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(rd_vld == e.vld, {e.tag, " rd_vld"}, 64'(rd_vld), 64'(e.vld));
        if (e.vld) chk(rd_data == e.data, {e.tag, " rd_data"}, rd_data, e.data);
        chk(act_set == e.set, {e.tag, " act_set"}, 64'(act_set), 64'(e.set));
        if (e.set) chk(act_set_id == 5'(e.sid), {e.tag, " act_set_id"}, 64'(act_set_id), 64'(e.sid));
        chk(act_clr == e.clr, {e.tag, " act_clr"}, 64'(act_clr), 64'(e.clr));
        if (e.clr) chk(act_clr_id == 5'(e.cid), {e.tag, " act_clr_id"}, 64'(act_clr_id), 64'(e.cid));
        chk(acc_err == e.err, {e.tag, " acc_err"}, 64'(acc_err), 64'(e.err));
      end else begin
        chk(!rd_vld && !act_set && !act_clr && !acc_err, "R9 idle quiet",
            {60'd0, rd_vld, act_set, act_clr, acc_err}, 64'd0);
      end
    end
  end

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk({rd_vld, act_set, act_clr, acc_err, fiq_en, irq_en} == '0, "R11 outputs in reset",
        64'({rd_vld, act_set, act_clr, acc_err, fiq_en, irq_en}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fiq_en && !irq_en, "R11 enables after reset", 64'({fiq_en, irq_en}), 64'd0);
    rd(SEL_PMASK, 64'd0, "R11 pmask");
    rd(SEL_BP0,   64'd0, "R11 bp0");
    rd(SEL_BP1,   64'd0, "R11 bp1");
    rd(SEL_GEN0,  64'd0, "R11 gen0");
    rd(SEL_GEN1,  64'd0, "R11 gen1");

    // R8 control word
    rd(SEL_CTRL, 64'h440, "R8 ctrl");
    wr(SEL_CTRL, 64'hFFFF_FFFF_FFFF_FFFF, "R8 ctrl write");
    rd(SEL_CTRL, 64'h440, "R8 ctrl after write");

    // R5 priority mask
    wr(SEL_PMASK, 64'hFFFF_0000_0000_01A5, "R5 pmask write");
    rd(SEL_PMASK, 64'hA5, "R5 pmask");

    // R6 binary points
    wr(SEL_BP0, 64'hFD, "R6 bp0 write");
    rd(SEL_BP0, 64'd5, "R6 bp0");
    wr(SEL_BP1, 64'h2, "R6 bp1 write");
    rd(SEL_BP1, 64'd2, "R6 bp1");
    rd(SEL_BP0, 64'd5, "R6 bp0 untouched");

    // R7 enables
    wr(SEL_GEN0, 64'h3, "R7 gen0 write");
    chk(fiq_en && !irq_en, "R7 fiq on", 64'({fiq_en, irq_en}), 64'b10);
    rd(SEL_GEN0, 64'd1, "R7 gen0");
    wr(SEL_GEN1, 64'h2, "R7 gen1 bit1 only");
    chk(!irq_en, "R7 irq stays off", 64'(irq_en), 64'd0);
    wr(SEL_GEN1, 64'h1, "R7 gen1 write");
    chk(irq_en && fiq_en, "R7 irq on", 64'({fiq_en, irq_en}), 64'b11);
    wr(SEL_GEN0, 64'h0, "R7 gen0 clear");
    chk(!fiq_en && irq_en, "R7 fiq off", 64'({fiq_en, irq_en}), 64'b01);
    rd(SEL_GEN1, 64'd1, "R7 gen1");

    // R1 acknowledge
    pend_bits = 32'h0000_8010;
    access(1, 0, SEL_ACK, '0, mk(1, 64'd4, 1, 4, 0, 0, 0, "R1 ack mixed"));
    pend_bits = 32'h8000_0000;
    access(1, 0, SEL_ACK, '0, mk(1, 64'd31, 1, 31, 0, 0, 0, "R1 ack top"));
    pend_bits = 32'h0000_0001;
    access(1, 0, SEL_ACK, '0, mk(1, 64'd0, 1, 0, 0, 0, 0, "R1 ack bit0"));
    pend_bits = 32'hFFFF_FFFF;
    access(1, 0, SEL_ACK, '0, mk(1, 64'd0, 1, 0, 0, 0, 0, "R1 ack all"));
    pend_bits = 32'h0040_0000;
    access(1, 0, SEL_ACK, '0, mk(1, 64'd22, 1, 22, 0, 0, 0, "R1 ack single"));

    // R2 empty acknowledge
    pend_bits = 32'h0;
    access(1, 0, SEL_ACK, '0, mk(1, 64'd1023, 0, 0, 0, 0, 0, "R2 ack empty"));

    // R3 end of interrupt
    access(0, 1, SEL_EOI, 64'd7,  mk(0, '0, 0, 0, 1, 7, 0, "R3 eoi 7"));
    access(0, 1, SEL_EOI, 64'd31, mk(0, '0, 0, 0, 1, 31, 0, "R3 eoi 31"));
    access(0, 1, SEL_EOI, 64'd0,  mk(0, '0, 0, 0, 1, 0, 0, "R3 eoi 0"));

    // R4 out of range end of interrupt
    access(0, 1, SEL_EOI, 64'd32, mk(0, '0, 0, 0, 0, 0, 1, "R4 eoi 32"));
    access(0, 1, SEL_EOI, 64'h100_0000_0003, mk(0, '0, 0, 0, 0, 0, 1, "R4 eoi high"));

    // R9 unsupported accesses
    access(1, 0, SEL_EOI, '0, mk(1, 64'd0, 0, 0, 0, 0, 1, "R9 read eoi"));
    pend_bits = 32'h0000_0100;
    access(0, 1, SEL_ACK, 64'h5, mk(0, '0, 0, 0, 0, 0, 1, "R9 write ack"));
    access(1, 0, 4'd9, '0, mk(1, 64'd0, 0, 0, 0, 0, 1, "R9 read sel9"));
    access(0, 1, 4'd12, 64'h33, mk(0, '0, 0, 0, 0, 0, 1, "R9 write sel12"));
    access(0, 1, 4'd15, 64'h1, mk(0, '0, 0, 0, 0, 0, 1, "R9 write sel15"));
    rd(SEL_PMASK, 64'hA5, "R9 pmask unchanged");
    rd(SEL_GEN1, 64'd1, "R9 gen1 unchanged");

    // R10 both strobes
    access(1, 1, SEL_PMASK, 64'h33, mk(1, 64'd0, 0, 0, 0, 0, 1, "R10 both pmask"));
    rd(SEL_PMASK, 64'hA5, "R10 pmask unchanged");
    access(1, 1, SEL_ACK, 64'd3, mk(1, 64'd0, 0, 0, 0, 0, 1, "R10 both ack"));
    access(1, 1, SEL_EOI, 64'd3, mk(1, 64'd0, 0, 0, 0, 0, 1, "R10 both eoi"));
    chk(!fiq_en && irq_en, "R10 enables unchanged", 64'({fiq_en, irq_en}), 64'b01);

    repeat (3) @(negedge clk);
    done = 1;
    chk(q.size() == 0, "R1 queue drained", 64'(q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule